// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block sits beside a memory-card controller and gives software a small window onto the slot. It offers four defined words on a word-addressed register bus. Two of them are fixed: an identification word and a decode word. One word always reads zero. The fourth is a status word that carries two flags. The first flag mirrors the slot's write-protect switch and follows it in both directions. The second flag is a sticky record that a card was inserted.

The insertion flag drives the block's interrupt output directly. Once set, it stays set until software writes a one to that bit position. Both slot inputs are asynchronous to the bus clock, so each passes through a synchronizer before it reaches the status flags. Read data is combinational from the word address. A write takes effect on the clock edge at which the write strobe is sampled.

Top module: `cardSlotRegs`

## Requirements
- R1: After reset the status word (address 2) reads 0x0 and irqOut is low.
- R2: Address 0 reads 0x41034003, address 1 reads 0x00000000 and address 3 reads 0x00000011, whatever the slot inputs are.
- R3: Addresses 4 to 15 read 0x00000000, and writes to them leave the status word unchanged.
- R4: Status bit 0 equals wpLevel delayed by two clock edges. It rises and falls with the input. Status bits 31:4, 2 and 1 always read 0.
- R5: Status bit 3 becomes 1 on the third clock edge after cardInsert goes high. It stays 1 after cardInsert returns low.
- R6: A write to address 2 with data bit 3 equal to 1 clears status bit 3 on that clock edge. A write to address 2 with data bit 3 equal to 0 leaves bit 3 unchanged. No write changes status bit 0.
- R7: Writes of any data to addresses 0, 1 and 3 change no register, and later reads return the same values as before.
- R8: If the synchronized card-insert signal is high on the edge of a clearing write, the set wins and status bit 3 stays 1.
- R9: irqOut equals status bit 3 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W (4) | Word address of the access |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr, combinational |
| wpLevel | input | 1 | Write-protect switch level, asynchronous |
| cardInsert | input | 1 | Card-insertion event, asynchronous, active high |
| irqOut | output | 1 | Card-insertion interrupt |

## Verification
The hardest case to reach is a clearing write on the same edge that the synchronized insert signal is high. It depends on the synchronizer delay, and the only signal the bench can drive is the raw input, two stages upstream. The bench therefore holds cardInsert high for several cycles, so the synchronized value is certainly high, and then issues the clearing write. A clear to a latched flag whose input has already fallen gives the contrasting case. Every address is read back under all four combinations of the two flags, and the synchronizer latency is checked one edge before and at the edge where each flag should change.

// File: rtl/cardslot_pkg.sv
package cardslot_pkg;
  localparam int DATA_W   = 32;
  localparam int WP_BIT   = 0;
  localparam int CARD_BIT = 3;

  typedef struct packed {
    logic pickId;
    logic pickStat;
    logic pickDecode;
    logic ackCard;
  } slotStrobe_t;
endpackage

// File: rtl/cardSlotSync.sv
module cardSlotSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/cardSlotCtrl.sv
module cardSlotCtrl
  import cardslot_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              ackBit,
  output slotStrobe_t       strobes
);
  localparam logic [ADDR_W-1:0] ID_WORD     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_WORD   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] DECODE_WORD = ADDR_W'(3);

  always_comb begin
    strobes            = '0;
    strobes.pickId     = (regAddr == ID_WORD);
    strobes.pickStat   = (regAddr == STAT_WORD);
    strobes.pickDecode = (regAddr == DECODE_WORD);
    strobes.ackCard    = wrEn && (regAddr == STAT_WORD) && ackBit;
  end
endmodule

// File: rtl/cardSlotData.sv
module cardSlotData
  import cardslot_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       strobes,
  input  logic              syncWp,
  input  logic              syncCard,
  output logic [DATA_W-1:0] rdData,
  output logic              cardFlag
);
  logic [DATA_W-1:0] statusWord;

  // A set request outranks a software acknowledge on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN)                cardFlag <= 1'b0;
    else if (syncCard)        cardFlag <= 1'b1;
    else if (strobes.ackCard) cardFlag <= 1'b0;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[WP_BIT]   = syncWp;
    statusWord[CARD_BIT] = cardFlag;
  end

  always_comb begin
    rdData = '0;
    if (strobes.pickId)     rdData = ID_VALUE;
    if (strobes.pickStat)   rdData = statusWord;
    if (strobes.pickDecode) rdData = DECODE_VALUE;
  end
endmodule

// File: rtl/cardSlotRegs.sv
module cardSlotRegs
  import cardslot_pkg::*;
#(
  parameter int                ADDR_W       = 4,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              wpLevel,
  input  logic              cardInsert,
  output logic              irqOut
);
  slotStrobe_t strobes;
  logic [1:0]  syncPair;
  logic        syncWp;
  logic        syncCard;
  logic        cardFlag;
  logic        unusedBits;

  assign unusedBits = ^{wrData[DATA_W-1:CARD_BIT+1], wrData[CARD_BIT-1:0]};

  cardSlotSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({cardInsert, wpLevel}), .syncOut(syncPair)
  );
  assign syncWp   = syncPair[0];
  assign syncCard = syncPair[1];

  cardSlotCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr), .wrEn(wrEn), .ackBit(wrData[CARD_BIT]), .strobes(strobes)
  );

  cardSlotData #(.ID_VALUE(ID_VALUE), .DECODE_VALUE(DECODE_VALUE)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .syncWp(syncWp), .syncCard(syncCard),
    .rdData(rdData), .cardFlag(cardFlag)
  );

  assign irqOut = cardFlag;
endmodule

// File: rtl/cardSlotRegs_chk.sv
module cardSlotRegs_chk #(
  parameter int          ADDR_W       = 4,
  parameter logic [31:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [31:0] DECODE_VALUE = 32'h0000_0011
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              irqOut,
  input logic              syncWp,
  input logic              syncCard
);
  logic clearWrite;
  assign clearWrite = wrEn && (regAddr == ADDR_W'(2)) && wrData[3];

  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (rdData == ID_VALUE));                          // R2
  AST_DECODE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(3)) |-> (rdData == DECODE_VALUE));                      // R2
  AST_HIGH_WORDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(3)) |-> (rdData == 32'h0));                              // R3
  AST_WP_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(2)) |-> (rdData[0] == syncWp && rdData[2:1] == 2'b0));  // R4
  AST_CARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clearWrite) |=> irqOut);                                        // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (clearWrite && !syncCard) |=> !irqOut);                                     // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    syncCard |=> irqOut);                                                       // R8
  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(2)) |-> (rdData[3] == irqOut));                         // R9
endmodule

bind cardSlotRegs cardSlotRegs_chk #(
  .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE), .DECODE_VALUE(DECODE_VALUE)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut), .syncWp(syncWp), .syncCard(syncCard)
);

// File: tb/cardSlotRegs_test.sv
`timescale 1ns/1ps
module cardSlotRegs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        wpLevel = 1'b0;
  logic        cardInsert = 1'b0;
  logic        irqOut;
  int          checks = 0;
  int          errors = 0;
  logic        finished = 1'b0;

  always #4 clk = ~clk;

  cardSlotRegs uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .wpLevel(wpLevel), .cardInsert(cardInsert), .irqOut(irqOut)
  );

  function automatic logic [31:0] expWord(input int a, input logic wp, input logic card);
    case (a)
      0:       return 32'h4103_4003;
      2:       return {28'h0, card, 2'b00, wp};
      3:       return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readWord(input int a, output logic [31:0] v);
    regAddr = 4'(a);
    #1;
    v = rdData;
  endtask

  task automatic writeWord(input int a, input logic [31:0] d);
    regAddr = 4'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic checkStatus(input string req, input logic wp, input logic card);
    logic [31:0] v;
    readWord(2, v);
    check(req, v, expWord(2, wp, card));
    check({req, "/R9 irq"}, {31'h0, irqOut}, {31'h0, card});
  endtask

  task automatic sweepAll(input logic wp, input logic card);
    logic [31:0] v;
    for (int a = 0; a < 16; a++) begin
      readWord(a, v);
      if (a < 4) check("R2/R4 sweep", v, expWord(a, wp, card));
      else       check("R3 high word", v, expWord(a, wp, card));
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog got=hang expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    checkStatus("R1 reset", 1'b0, 1'b0);
    sweepAll(1'b0, 1'b0);

    // R4 write-protect latency and both directions
    wpLevel = 1'b1;
    cycles(1); checkStatus("R4 wp one edge", 1'b0, 1'b0);
    cycles(1); checkStatus("R4 wp rise", 1'b1, 1'b0);
    sweepAll(1'b1, 1'b0);
    wpLevel = 1'b0;
    cycles(2); checkStatus("R4 wp fall", 1'b0, 1'b0);

    // R5 card latch latency and stickiness
    cardInsert = 1'b1;
    cycles(2); checkStatus("R5 two edges", 1'b0, 1'b0);
    cycles(1); checkStatus("R5 third edge", 1'b0, 1'b1);
    cardInsert = 1'b0;
    cycles(5); checkStatus("R5 sticky", 1'b0, 1'b1);
    sweepAll(1'b0, 1'b1);
    wpLevel = 1'b1;
    cycles(3); sweepAll(1'b1, 1'b1);

    // R3 and R7: writes elsewhere change nothing
    for (int a = 0; a < 16; a++) begin
      if (a != 2) writeWord(a, 32'hFFFF_FFFF);
    end
    checkStatus("R7/R3 ignored writes", 1'b1, 1'b1);
    sweepAll(1'b1, 1'b1);

    // R6 write without bit 3, then with bit 3 set
    writeWord(2, 32'hFFFF_FFF7);
    checkStatus("R6 no bit3", 1'b1, 1'b1);
    writeWord(2, 32'h0000_0009);
    checkStatus("R6 clear", 1'b1, 1'b0);
    sweepAll(1'b1, 1'b0);

    // R8 set wins over clear
    cardInsert = 1'b1;
    cycles(4);
    writeWord(2, 32'h0000_0008);
    checkStatus("R8 set wins", 1'b1, 1'b1);
    cardInsert = 1'b0;
    cycles(3);
    writeWord(2, 32'h0000_0008);
    checkStatus("R6 clear after fall", 1'b1, 1'b0);

    // short pulse is still captured
    cardInsert = 1'b1; cycles(1); cardInsert = 1'b0;
    cycles(3); checkStatus("R5 pulse", 1'b1, 1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule